// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit memory address. It holds four 16-bit segment bases: code, data, stack and extra. It chooses which base applies to an access and adds that base, scaled by sixteen, to the offset. An execution pipeline drives the block each cycle with three things: the kind of access, the offset value, and a tag that names the register the offset came from. The block answers in the same cycle with the physical address. A separate write port loads any of the four segment bases.

The base is normally picked from the access kind and the offset tag. An instruction fetch uses the code base. A push or pop uses the stack base. A string destination uses the extra base. An ordinary data operand uses the stack base when it is addressed through the frame pointer or the stack pointer, and the data base otherwise. An explicit segment override replaces this choice for every access kind except instruction fetch.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals the selected segment base times 16 plus the zero-extended `offset`. It is 20 bits wide, and its low four bits always equal the low four bits of `offset`.
- R2: Any carry out of bit 19 of that sum is dropped, so the address wraps modulo 1 MB. For example, base FFFFh with offset 0020h gives 00010h.
- R3: When `acc_kind` = 00 (instruction fetch), the code base is used. The offset tag and any override have no effect on this choice.
- R4: When `acc_kind` = 01 (data operand), there is no override, and `off_tag` is 100 (frame pointer) or 101 (stack pointer), the stack base is used.
- R5: When `acc_kind` = 01, there is no override, and `off_tag` has any other value (000 direct, 001 BX, 010 SI, 011 DI, 110 IP, 111 spare), the data base is used.
- R6: When `acc_kind` = 10 (push/pop stack access) and there is no override, the stack base is used.
- R7: When `acc_kind` = 11 (string destination) and there is no override, the extra base is used.
- R8: When `ov_en` = 1 and the access is not a fetch, `ov_sel` picks the base: 00 extra, 01 code, 10 stack, 11 data.
- R9: A write with `seg_we` = 1 loads `seg_wdata` into the base named by `seg_wsel`, using the same code values as R8. The new value first shows in `phys_addr` one clock later. An address formed in the write cycle itself still uses the old value. Bases that are not written keep their value.
- R10: A synchronous active-high `rst` sets the code base to FFFFh and the other three bases to 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment base write enable |
| seg_wsel | input | 2 | Base to write (00 extra, 01 code, 10 stack, 11 data) |
| seg_wdata | input | 16 | Value to write |
| acc_kind | input | 2 | Access kind (00 fetch, 01 data, 10 stack, 11 string destination) |
| off_tag | input | 3 | Register the offset came from |
| ov_en | input | 1 | Segment override enable |
| ov_sel | input | 2 | Override base select |
| offset | input | 16 | Offset value |
| phys_addr | output | 20 | Physical address |

## Verification
A segment base write and an address formed from that same base can land in the same cycle. The bench provokes this by writing a base while it issues an access that selects it, and then repeating the access on the next cycle. It expects the old base in the write cycle and the new base afterwards. The bench's scoreboard keeps its own copy of the bases and updates that copy only after the issuing cycle. A long random run mixes writes, overrides and access kinds, so this collision recurs many times under varied selections.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'b00,
        ACC_DATA   = 2'b01,
        ACC_STACK  = 2'b10,
        ACC_STRDST = 2'b11
    } acc_kind_e;

    typedef enum logic [2:0] {
        TAG_DIRECT = 3'b000,
        TAG_BX     = 3'b001,
        TAG_SI     = 3'b010,
        TAG_DI     = 3'b011,
        TAG_BP     = 3'b100,
        TAG_SP     = 3'b101,
        TAG_IP     = 3'b110,
        TAG_SPARE  = 3'b111
    } off_tag_e;

    typedef struct packed {
        acc_kind_e kind;
        off_tag_e  tag;
        logic      ov_en;
        seg_id_e   ov_sel;
    } acc_req_t;

    // Base chosen when no override applies.
    function automatic seg_id_e default_seg(acc_kind_e kind, off_tag_e tag);
        seg_id_e id;
        unique case (kind)
            ACC_FETCH:  id = SEG_CODE;
            ACC_STACK:  id = SEG_STACK;
            ACC_STRDST: id = SEG_EXTRA;
            default:    id = (tag == TAG_BP || tag == TAG_SP) ? SEG_STACK : SEG_DATA;
        endcase
        return id;
    endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_pkg::*;
#(
    parameter int          SEG_W    = 16,
    parameter logic [15:0] CODE_RST = 16'hFFFF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  seg_id_e                       wsel,
    input  logic [SEG_W-1:0]              wdata,
    output logic [NUM_SEG-1:0][SEG_W-1:0] seg_q
);

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        localparam logic [SEG_W-1:0] RST_VAL =
            (i == int'(SEG_CODE)) ? SEG_W'(CODE_RST) : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                seg_q[i] <= RST_VAL;
            end else if (we && wsel == seg_id_e'(i)) begin
                seg_q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/seg_chooser.sv
module seg_chooser
    import seg_pkg::*;
(
    input  acc_req_t req,
    output seg_id_e  sel
);

    always_comb begin
        sel = default_seg(req.kind, req.tag);
        if (req.ov_en && req.kind != ACC_FETCH) begin
            sel = req.ov_sel;
        end
    end

endmodule

// File: rtl/addr_former.sv
module addr_former #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);

    // Sum is formed at ADDR_W bits, so the top carry falls off.
    always_comb begin
        addr = {seg, {SHIFT{1'b0}}} + ADDR_W'(off);
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int          SEG_W    = 16,
    parameter int          OFF_W    = 16,
    parameter int          SHIFT    = 4,
    parameter logic [15:0] CODE_RST = 16'hFFFF,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seg_we,
    input  logic [1:0]        seg_wsel,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic [1:0]        acc_kind,
    input  logic [2:0]        off_tag,
    input  logic              ov_en,
    input  logic [1:0]        ov_sel,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys_addr
);

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
    acc_req_t                      req;
    seg_id_e                       sel_id;
    logic [SEG_W-1:0]              base;

    always_comb begin
        req.kind   = acc_kind_e'(acc_kind);
        req.tag    = off_tag_e'(off_tag);
        req.ov_en  = ov_en;
        req.ov_sel = seg_id_e'(ov_sel);
    end

    seg_bank #(
        .SEG_W    (SEG_W),
        .CODE_RST (CODE_RST)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (seg_we),
        .wsel  (seg_id_e'(seg_wsel)),
        .wdata (seg_wdata),
        .seg_q (seg_q)
    );

    seg_chooser u_choose (
        .req (req),
        .sel (sel_id)
    );

    assign base = seg_q[sel_id];

    addr_former #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_form (
        .seg  (base),
        .off  (offset),
        .addr (phys_addr)
    );

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    seg_we,
    input logic [1:0]              seg_wsel,
    input logic [SEG_W-1:0]        seg_wdata,
    input logic [1:0]              acc_kind,
    input logic [2:0]              off_tag,
    input logic                    ov_en,
    input logic [1:0]              ov_sel,
    input logic [OFF_W-1:0]        offset,
    input logic [ADDR_W-1:0]       phys_addr,
    input logic [1:0]              chosen,
    input logic [3:0][SEG_W-1:0]   seg_q
);

    assert_low_nibble_R1: assert property (@(posedge clk) disable iff (rst)
        phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);

    assert_fetch_code_R3: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'b00 |-> chosen == 2'b01);

    assert_data_frame_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == 2'b01 && !ov_en && (off_tag == 3'b100 || off_tag == 3'b101))
        |-> chosen == 2'b10);

    assert_data_plain_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == 2'b01 && !ov_en && off_tag != 3'b100 && off_tag != 3'b101)
        |-> chosen == 2'b11);

    assert_stack_kind_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == 2'b10 && !ov_en) |-> chosen == 2'b10);

    assert_strdst_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == 2'b11 && !ov_en) |-> chosen == 2'b00);

    assert_override_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_kind != 2'b00 && ov_en) |-> chosen == ov_sel);

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        seg_we |=> seg_q[$past(seg_wsel)] == $past(seg_wdata));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !seg_we |=> $stable(seg_q));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seg_we    (seg_we),
    .seg_wsel  (seg_wsel),
    .seg_wdata (seg_wdata),
    .acc_kind  (acc_kind),
    .off_tag   (off_tag),
    .ov_en     (ov_en),
    .ov_sel    (ov_sel),
    .offset    (offset),
    .phys_addr (phys_addr),
    .chosen    (sel_id),
    .seg_q     (seg_q)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_wsel = '0;
    logic [15:0] seg_wdata = '0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  off_tag = '0;
    logic        ov_en = 1'b0;
    logic [1:0]  ov_sel = '0;
    logic [15:0] offset = '0;
    logic [19:0] phys_addr;

    seg_addr_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .seg_we    (seg_we),
        .seg_wsel  (seg_wsel),
        .seg_wdata (seg_wdata),
        .acc_kind  (acc_kind),
        .off_tag   (off_tag),
        .ov_en     (ov_en),
        .ov_sel    (ov_sel),
        .offset    (offset),
        .phys_addr (phys_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [19:0] addr;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] shadow [4];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;

    // Expected address from the requirements.
    function automatic logic [19:0] model(logic [1:0] k, logic [2:0] t, logic oe,
                                          logic [1:0] os, logic [15:0] off);
        logic [1:0] s;
        if (k == 2'b00)                       s = 2'b01;
        else if (oe)                          s = os;
        else if (k == 2'b10)                  s = 2'b10;
        else if (k == 2'b11)                  s = 2'b00;
        else if (t == 3'b100 || t == 3'b101)  s = 2'b10;
        else                                  s = 2'b11;
        return {shadow[s], 4'h0} + {4'h0, off};
    endfunction

    task automatic drive(input logic [1:0] k, input logic [2:0] t, input logic oe,
                         input logic [1:0] os, input logic [15:0] off,
                         input logic we, input logic [1:0] ws, input logic [15:0] wd,
                         input string req);
        exp_t it;
        @(negedge clk);
        acc_kind  = k;
        off_tag   = t;
        ov_en     = oe;
        ov_sel    = os;
        offset    = off;
        seg_we    = we;
        seg_wsel  = ws;
        seg_wdata = wd;
        it.addr = model(k, t, oe, os, off);
        it.req  = req;
        sb_q.push_back(it);
        if (we) shadow[ws] = wd;
    endtask

    task automatic wr(input logic [1:0] ws, input logic [15:0] wd);
        drive(2'b00, 3'b110, 1'b0, 2'b00, 16'h0000, 1'b1, ws, wd, "R9");
    endtask

    // Monitor: compare each expected item against the output mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (phys_addr !== it.addr) begin
                    n_errors++;
                    $display("FAIL %s: phys_addr=%05h expected=%05h", it.req, phys_addr, it.addr);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        shadow[0] = 16'h0000;
        shadow[1] = 16'hFFFF;
        shadow[2] = 16'h0000;
        shadow[3] = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset values
        drive(2'b00, 3'b110, 1'b0, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0, "R10");
        drive(2'b01, 3'b000, 1'b0, 2'b00, 16'h0005, 1'b0, 2'b00, 16'h0, "R10");
        drive(2'b10, 3'b101, 1'b0, 2'b00, 16'h0007, 1'b0, 2'b00, 16'h0, "R10");

        // R9: write and same-cycle read of the same base
        drive(2'b01, 3'b001, 1'b0, 2'b00, 16'h0000, 1'b1, 2'b11, 16'h1234, "R9");
        drive(2'b01, 3'b001, 1'b0, 2'b00, 16'h0000, 1'b0, 2'b00, 16'h0, "R9");
        wr(2'b00, 16'h1000);
        wr(2'b10, 16'h3000);

        // R1: plain sum
        drive(2'b01, 3'b010, 1'b0, 2'b00, 16'h5678, 1'b0, 2'b00, 16'h0, "R1");
        // R2: wrap past 1 MB with code base FFFF
        drive(2'b00, 3'b110, 1'b0, 2'b00, 16'h0020, 1'b0, 2'b00, 16'h0, "R2");
        wr(2'b01, 16'h2000);
        // R3: fetch ignores tag and override
        drive(2'b00, 3'b010, 1'b1, 2'b11, 16'h0044, 1'b0, 2'b00, 16'h0, "R3");
        drive(2'b00, 3'b100, 1'b1, 2'b10, 16'h0045, 1'b0, 2'b00, 16'h0, "R3");
        // R4
        drive(2'b01, 3'b100, 1'b0, 2'b00, 16'h0010, 1'b0, 2'b00, 16'h0, "R4");
        drive(2'b01, 3'b101, 1'b0, 2'b00, 16'h0011, 1'b0, 2'b00, 16'h0, "R4");
        // R5
        for (int t = 0; t < 8; t++) begin
            if (t != 4 && t != 5)
                drive(2'b01, 3'(t), 1'b0, 2'b00, 16'h0020, 1'b0, 2'b00, 16'h0, "R5");
        end
        // R6, R7
        drive(2'b10, 3'b011, 1'b0, 2'b00, 16'hFFFE, 1'b0, 2'b00, 16'h0, "R6");
        drive(2'b11, 3'b011, 1'b0, 2'b00, 16'h0102, 1'b0, 2'b00, 16'h0, "R7");
        // R8: each override code for each non-fetch kind
        for (int k = 1; k < 4; k++) begin
            for (int s = 0; s < 4; s++) begin
                drive(2'(k), 3'b011, 1'b1, 2'(s), 16'h0ABC, 1'b0, 2'b00, 16'h0, "R8");
            end
        end

        // Random mix, R1 through R9 together
        for (int i = 0; i < 400; i++) begin
            drive(2'($urandom), 3'($urandom), 1'($urandom), 2'($urandom),
                  16'($urandom), 1'(($urandom % 4) == 0), 2'($urandom), 16'($urandom),
                  "R1/R9 random");
        end

        // R10: reset again restores bases
        @(negedge clk);
        rst = 1'b1;
        shadow[0] = 16'h0000;
        shadow[1] = 16'hFFFF;
        shadow[2] = 16'h0000;
        shadow[3] = 16'h0000;
        @(negedge clk);
        rst = 1'b0;
        drive(2'b00, 3'b110, 1'b0, 2'b00, 16'h0003, 1'b0, 2'b00, 16'h0, "R10");
        drive(2'b11, 3'b011, 1'b0, 2'b00, 16'h0009, 1'b0, 2'b00, 16'h0, "R10");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule